// File: doc/BRIEF.md
# Low-Power Mode Clock Enable Controller

This block turns three low-power control bits of a small 16-bit controller's status register into a CPU run signal and two clock-enable strobes, all timed on the main clock. The auxiliary enable follows the rising edges of an external low-frequency clock. The sub-main enable comes either from the main clock itself or from that low-frequency clock. Each enable passes through its own power-of-two divider after the source has been chosen.

Software writes the three bits through a small write port. A second write port sets the sub-main source and the two divider codes. When an interrupt request arrives, or while its handler is running, the block ignores the stored bits. The CPU and both enables then run. When the handler ends and the bits are still set, the stopped state returns on the next cycle with no further action.

Top module: `lpm_clkgen`

## Requirements
- R1: After reset, `cpu_run` is 1. `sub_en` is high on every main clock cycle. `aux_en` pulses once for each rising edge of `lf_clk_in`.
- R2: Each rising edge of `lf_clk_in` passes through a two-flop synchronizer and becomes exactly one single-cycle pulse of the auxiliary source. With no division, that pulse appears on `aux_en`.
- R3: A cycle with `lp_wr` high loads `lp_wdata`. Bit 0 is the CPU-halt bit (status bit 4), bit 1 is the oscillator-stop bit (status bit 5), and bit 2 is the sub-clock-stop bit (status bit 7).
- R4: After a write that sets the CPU-halt bit, and with no wake source present, `cpu_run` is still 1 one cycle later and is 0 two cycles later.
- R5: When the oscillator-stop bit is set, `aux_en` stays low. `sub_en` keeps running if it is sourced from the main clock.
- R6: When the sub-clock-stop bit is set, `sub_en` stays low.
- R7: The sub-main source is set by `cfg_sub_lf`. A value of 0 selects the main clock, so that with no division `sub_en` is high every cycle. A value of 1 selects the low-frequency clock, so that `sub_en` pulses once per `lf_clk_in` rise. That low-frequency source is also stopped by the oscillator-stop bit.
- R8: Divider codes 0, 1, 2 and 3 produce one output pulse per 1, 2, 4 and 8 source pulses. `cfg_aux_div` sets the auxiliary divider and `cfg_sub_div` sets the sub-main divider.
- R9: `irq_req` drives `cpu_run` to 1 at the first clock edge after it is seen, even when the CPU-halt bit is set.
- R10: While `isr_active` is high, `cpu_run`, `aux_en` and `sub_en` all run as if the three low-power bits were clear.
- R11: When `isr_active` and `irq_req` drop while the low-power bits are still set, the CPU and the affected enables stop again from the next cycle.
- R12: A synchronous reset clears the low-power bits. It also sets the sub-main source back to the main clock and both divider codes back to 0, whatever was written before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_clk_in | input | 1 | Asynchronous low-frequency clock |
| lp_wr | input | 1 | Write strobe for the low-power bits |
| lp_wdata | input | 3 | {sub stop, oscillator stop, CPU halt} |
| cfg_wr | input | 1 | Write strobe for the clock configuration |
| cfg_sub_lf | input | 1 | Sub-main source: 0 main clock, 1 low-frequency clock |
| cfg_aux_div | input | 2 | Auxiliary divider code |
| cfg_sub_div | input | 2 | Sub-main divider code |
| irq_req | input | 1 | Pending interrupt request (wake) |
| isr_active | input | 1 | Interrupt handler in progress |
| cpu_run | output | 1 | CPU may fetch and execute |
| aux_en | output | 1 | Auxiliary clock enable strobe |
| sub_en | output | 1 | Sub-main clock enable strobe |

## Verification
A stale low-power bit or override term shows up on `cpu_run` within two main cycles of the write or wake change that should have cleared it. The bench samples exactly there. A faulty synchronizer, source select or divider counter changes the number of enable strobes in a window. The bench therefore counts strobes over windows of 64 cycles, a whole multiple of the low-frequency period. With division by 8, a single lost or extra pulse changes the count by a full unit.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int DIV_SEL_W = 2;
    localparam int DIV_CNT_W = (1 << DIV_SEL_W) - 1;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic sub_off;
        logic osc_off;
        logic cpu_off;
    } lp_bits_t;

    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_LF   = 1'b1
    } sub_src_e;

    typedef struct packed {
        sub_src_e             src;
        logic [DIV_SEL_W-1:0] aux_div;
        logic [DIV_SEL_W-1:0] sub_div;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{src: SRC_MAIN, aux_div: '0, sub_div: '0};

    function automatic logic [DIV_CNT_W-1:0] div_mask(input logic [DIV_SEL_W-1:0] sel);
        logic [DIV_CNT_W:0] one_hot;
        one_hot = (DIV_CNT_W+1)'(1) << sel;
        return DIV_CNT_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/lpm_sync_rise.sv
module lpm_sync_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its previous value
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-1:0], async_i};
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R2

endmodule

// File: rtl/lpm_ctrl_regs.sv
module lpm_ctrl_regs
    import lpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lp_wr,
    input  lp_bits_t lp_wdata,
    input  logic     cfg_wr,
    input  clk_cfg_t cfg_wdata,
    input  logic     irq_req,
    input  logic     isr_active,
    output lp_bits_t lp_o,
    output clk_cfg_t cfg_o,
    output logic     wake_o,
    output logic     cpu_run_o
);
    lp_bits_t lp_q;
    clk_cfg_t cfg_q;
    logic     run_q;

    assign wake_o = irq_req | isr_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_q  <= '0;
            cfg_q <= CFG_RESET;
            run_q <= 1'b1;
        end else begin
            if (lp_wr)  lp_q  <= lp_wdata;
            if (cfg_wr) cfg_q <= cfg_wdata;
            run_q <= ~lp_q.cpu_off | wake_o;
        end
    end

    assign lp_o      = lp_q;
    assign cfg_o     = cfg_q;
    assign cpu_run_o = run_q;

    AST_WAKE_RUNS: assert property (@(posedge clk) disable iff (rst)
        (irq_req || isr_active) |=> cpu_run_o); // R9

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (lp_q.cpu_off && !irq_req && !isr_active) |=> !cpu_run_o); // R4

endmodule

// File: rtl/lpm_en_div.sv
module lpm_en_div
    import lpm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 src_i,
    input  logic                 gate_i,
    input  logic [DIV_SEL_W-1:0] sel_i,
    output logic                 en_o
);
    logic [DIV_CNT_W-1:0] cnt_q;
    logic [DIV_CNT_W-1:0] mask;
    logic                 pass;
    logic                 hit;

    assign mask = div_mask(sel_i);
    assign pass = src_i & gate_i;
    assign hit  = (cnt_q & mask) == mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            en_o  <= 1'b0;
        end else begin
            en_o <= pass & hit;
            if (pass) cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_EN_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
        en_o |-> $past(src_i && gate_i)); // R8

    AST_DIV1_PASS: assert property (@(posedge clk) disable iff (rst)
        (sel_i == '0 && src_i && gate_i) |=> en_o); // R8

endmodule

// File: rtl/lpm_clkgen.sv
module lpm_clkgen
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lf_clk_in,
    input  logic       lp_wr,
    input  logic [2:0] lp_wdata,
    input  logic       cfg_wr,
    input  logic       cfg_sub_lf,
    input  logic [1:0] cfg_aux_div,
    input  logic [1:0] cfg_sub_div,
    input  logic       irq_req,
    input  logic       isr_active,
    output logic       cpu_run,
    output logic       aux_en,
    output logic       sub_en
);
    lp_bits_t lp;
    clk_cfg_t cfg;
    clk_cfg_t cfg_wdata;
    logic     wake;
    logic     lf_rise;
    logic     aux_gate;
    logic     sub_gate;
    logic     sub_src;

    assign cfg_wdata = '{src: sub_src_e'(cfg_sub_lf), aux_div: cfg_aux_div, sub_div: cfg_sub_div};

    lpm_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .lp_wr      (lp_wr),
        .lp_wdata   (lp_bits_t'(lp_wdata)),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .irq_req    (irq_req),
        .isr_active (isr_active),
        .lp_o       (lp),
        .cfg_o      (cfg),
        .wake_o     (wake),
        .cpu_run_o  (cpu_run)
    );

    lpm_sync_rise #(.STAGES(SYNC_STAGES)) u_lf_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (lf_clk_in),
        .rise_o  (lf_rise)
    );

    // Override: a wake source reopens every gate for as long as it lasts
    assign aux_gate = ~lp.osc_off | wake;
    assign sub_src  = (cfg.src == SRC_MAIN) ? 1'b1 : lf_rise;
    assign sub_gate = (~lp.sub_off | wake) & ((cfg.src == SRC_MAIN) | aux_gate);

    lpm_en_div u_aux_div (
        .clk    (clk),
        .rst    (rst),
        .src_i  (lf_rise),
        .gate_i (aux_gate),
        .sel_i  (cfg.aux_div),
        .en_o   (aux_en)
    );

    lpm_en_div u_sub_div (
        .clk    (clk),
        .rst    (rst),
        .src_i  (sub_src),
        .gate_i (sub_gate),
        .sel_i  (cfg.sub_div),
        .en_o   (sub_en)
    );

    AST_OSC_STOP_AUX: assert property (@(posedge clk) disable iff (rst)
        (lp.osc_off && !wake) |=> !aux_en); // R5

    AST_SUB_STOP: assert property (@(posedge clk) disable iff (rst)
        (lp.sub_off && !wake) |=> !sub_en); // R6

    AST_MAIN_FULL: assert property (@(posedge clk) disable iff (rst)
        (cfg.src == SRC_MAIN && cfg.sub_div == '0 && (!lp.sub_off || wake)) |=> sub_en); // R7

endmodule

// File: tb/test_lpm_clkgen.sv
`timescale 1ns/1ps
module test_lpm_clkgen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lf_clk_in = 1'b0;
    logic       lp_wr = 1'b0;
    logic [2:0] lp_wdata = '0;
    logic       cfg_wr = 1'b0;
    logic       cfg_sub_lf = 1'b0;
    logic [1:0] cfg_aux_div = '0;
    logic [1:0] cfg_sub_div = '0;
    logic       irq_req = 1'b0;
    logic       isr_active = 1'b0;
    logic       cpu_run, aux_en, sub_en;

    int checks = 0;
    int failures = 0;
    int n_cpu, n_aux, n_sub;

    always #2.5 clk = ~clk;

    // low-frequency clock: period of 8 main cycles
    initial begin
        forever begin
            repeat (4) @(negedge clk);
            lf_clk_in = ~lf_clk_in;
        end
    end

    lpm_clkgen i_lpm_clkgen (
        .clk(clk), .rst(rst), .lf_clk_in(lf_clk_in),
        .lp_wr(lp_wr), .lp_wdata(lp_wdata),
        .cfg_wr(cfg_wr), .cfg_sub_lf(cfg_sub_lf),
        .cfg_aux_div(cfg_aux_div), .cfg_sub_div(cfg_sub_div),
        .irq_req(irq_req), .isr_active(isr_active),
        .cpu_run(cpu_run), .aux_en(aux_en), .sub_en(sub_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic window64();
        n_cpu = 0; n_aux = 0; n_sub = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            n_cpu += int'(cpu_run);
            n_aux += int'(aux_en);
            n_sub += int'(sub_en);
        end
    endtask

    task automatic write_lp(input logic [2:0] v);
        lp_wdata = v; lp_wr = 1'b1;
        @(negedge clk);
        lp_wr = 1'b0;
    endtask

    task automatic write_cfg(input logic lf, input logic [1:0] ad, input logic [1:0] sd);
        cfg_sub_lf = lf; cfg_aux_div = ad; cfg_sub_div = sd; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 cpu_run after reset", int'(cpu_run), 1);
        repeat (8) @(negedge clk);
        window64();
        chk("R1 sub_en every cycle", n_sub, 64);
        chk("R2 aux_en per lf rise", n_aux, 8);
        chk("R1 cpu_run held", n_cpu, 64);
    endtask

    task automatic t_dividers();
        write_cfg(1'b0, 2'd0, 2'd1); window64(); chk("R8 sub div2", n_sub, 32);
        write_cfg(1'b0, 2'd0, 2'd2); window64(); chk("R8 sub div4", n_sub, 16);
        write_cfg(1'b0, 2'd0, 2'd3); window64(); chk("R8 sub div8", n_sub, 8);
        write_cfg(1'b0, 2'd2, 2'd0); window64(); chk("R8 aux div4", n_aux, 2);
        write_cfg(1'b0, 2'd1, 2'd0); window64(); chk("R8 aux div2", n_aux, 4);
        write_cfg(1'b0, 2'd0, 2'd0);
    endtask

    task automatic t_sub_stop();
        write_lp(3'b100); repeat (2) @(negedge clk);
        window64();
        chk("R6 sub stopped", n_sub, 0);
        chk("R6 aux unaffected", n_aux, 8);
        chk("R3 cpu bit not set", n_cpu, 64);
        write_lp(3'b000);
    endtask

    task automatic t_osc_stop();
        write_lp(3'b010); repeat (2) @(negedge clk);
        window64();
        chk("R5 aux stopped", n_aux, 0);
        chk("R5 sub on main unaffected", n_sub, 64);
        write_cfg(1'b1, 2'd0, 2'd0);
        window64();
        chk("R7 lf-sourced sub stopped by osc bit", n_sub, 0);
        write_lp(3'b000); repeat (2) @(negedge clk);
        window64();
        chk("R7 lf-sourced sub per rise", n_sub, 8);
        write_cfg(1'b1, 2'd0, 2'd1);
        window64();
        chk("R8 lf-sourced sub div2", n_sub, 4);
        write_cfg(1'b0, 2'd0, 2'd0);
    endtask

    task automatic t_cpu_halt_and_irq();
        write_lp(3'b001);
        chk("R4 cpu_run one cycle after write", int'(cpu_run), 1);
        @(negedge clk);
        chk("R4 cpu_run two cycles after write", int'(cpu_run), 0);
        window64();
        chk("R4 cpu stays halted", n_cpu, 0);
        chk("R3 sub bit not set", n_sub, 64);
        irq_req = 1'b1;
        @(negedge clk);
        chk("R9 irq wakes cpu", int'(cpu_run), 1);
        irq_req = 1'b0;
        @(negedge clk);
        chk("R11 halted after irq drop", int'(cpu_run), 0);
    endtask

    task automatic t_isr_override();
        write_lp(3'b111); repeat (2) @(negedge clk);
        window64();
        chk("R4 all stopped cpu", n_cpu, 0);
        chk("R5 all stopped aux", n_aux, 0);
        chk("R6 all stopped sub", n_sub, 0);
        isr_active = 1'b1; repeat (2) @(negedge clk);
        window64();
        chk("R10 cpu runs in isr", n_cpu, 64);
        chk("R10 aux runs in isr", n_aux, 8);
        chk("R10 sub runs in isr", n_sub, 64);
        isr_active = 1'b0;
        @(negedge clk);
        chk("R11 cpu stops on return", int'(cpu_run), 0);
        @(negedge clk);
        window64();
        chk("R11 aux stops on return", n_aux, 0);
        chk("R11 sub stops on return", n_sub, 0);
    endtask

    task automatic t_reset_clears();
        write_cfg(1'b1, 2'd3, 2'd3);
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R12 cpu_run after reset", int'(cpu_run), 1);
        repeat (8) @(negedge clk);
        window64();
        chk("R12 sub main div1", n_sub, 64);
        chk("R12 aux div1", n_aux, 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_dividers();
        t_sub_stop();
        t_osc_stop();
        t_cpu_halt_and_irq();
        t_isr_override();
        t_reset_clears();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule